// File: doc/BRIEF.md
# Multicycle Fetch-Execute Core

This block is a compact multicycle processor core for a four-operation subset of a 32-bit RISC instruction set. It walks a fixed control sequence. It fetches the word at the program counter and latches it into an instruction register. It then decodes that word, computes an effective address when the operation touches memory, and executes. A load takes one extra cycle to write back the returned word. The core then fetches again.

A single 32-bit memory port serves instruction fetches, operand reads and stores, each in its own cycle. The memory answers a read one clock after the address is presented. Register r0 is wired to zero. Memory is byte addressed and big-endian, and only word-aligned accesses are legal. A zero instruction word stops the core cleanly. A misaligned address or an unknown encoding stops it with a fault flag. The condition codes are brought out so the surrounding system can observe them.

Top module: `mcc_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `halted`, `fault` and `cc_flags` are 0, `mem_we` is 0 and `mem_addr` is 0, so the first fetch comes from byte address 0.
- R2: The PC advances by 4 on every fetch. Counted from reset release, the core spends 4 cycles on a store, set-high or AND instruction, 5 cycles on a load, and 3 cycles on the final zero word before `halted` rises.
- R3: Register r0 reads as zero. Loads or ANDs that name r0 as destination leave it zero, and a store of r0 writes 0.
- R4: Format 11 (bits 31:30) with op3 (bits 24:19) = 000000 is a load. Here rd is bits 29:25, rs1 is bits 18:14, bit 13 = 1 selects the sign-extended 13-bit immediate in bits 12:0, and rs2 is bits 4:0. The word at rs1 + offset goes to rd, and negative offsets are allowed.
- R5: Format 11 with op3 = 000100 is a store. It writes register rd to the word at rs1 + offset.
- R6: Format 00 with bits 24:22 = 100 is set-high. It writes its 22-bit constant (bits 21:0) into rd bits 31:10 and zeros bits 9:0.
- R7: Format 10 with op3 = 010001 is AND-with-flags. It writes rs1 AND (rs2 or the immediate) into rd and sets `cc_flags` = {N, Z, V, C}, where N is result bit 31, Z is result == 0, and V = C = 0. No other instruction changes `cc_flags`.
- R8: A load or store whose effective address has bits 1:0 not equal to 00 sets `fault` and halts, with no memory write. `halted` rises 3 cycles after that instruction's fetch begins.
- R9: The all-zero word halts with `fault` = 0. Once halted, the core stays halted and never asserts `mem_we`.
- R10: Any other encoding, for example format 01, sets `fault` and halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for the current access |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | The stop was caused by a bad address or encoding |
| cc_flags | output | 4 | Condition codes {N, Z, V, C} |

## Verification
In the execute cycle of the AND-with-flags operation, the register file write and the condition-code update land on the same clock edge. The source operands are read combinationally in that same cycle. The bench provokes this collision in two ways: with an AND whose destination is also its first source, and with an AND whose destination is r0, so that the result is thrown away while the flags still update. Each case is judged by storing the destination afterwards and comparing the memory word and `cc_flags` against values computed from the operands.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int XLEN     = 32;
    localparam int NREGS    = 32;
    localparam int RIDX_W   = $clog2(NREGS);
    localparam int IMM13_W  = 13;
    localparam int IMM22_W  = 22;
    localparam int LOW_W    = XLEN - IMM22_W;
    localparam int CC_W     = 4;

    localparam logic [1:0] FMT_SETHI = 2'b00;
    localparam logic [1:0] FMT_ALU   = 2'b10;
    localparam logic [1:0] FMT_MEM   = 2'b11;
    localparam logic [2:0] OP2_SETHI = 3'b100;
    localparam logic [5:0] OP3_LOAD  = 6'b000000;
    localparam logic [5:0] OP3_STORE = 6'b000100;
    localparam logic [5:0] OP3_ANDCC = 6'b010001;

    typedef enum logic [2:0] {
        ST_FETCH, ST_LDIR, ST_DECODE, ST_EXEC, ST_WBACK, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        OP_HALT, OP_LOAD, OP_STORE, OP_SETHI, OP_ANDCC, OP_BAD
    } opkind_e;

    typedef struct packed {
        opkind_e               kind;
        logic [RIDX_W-1:0]     rd;
        logic [RIDX_W-1:0]     rs1;
        logic [RIDX_W-1:0]     rs2;
        logic                  use_imm;
        logic [XLEN-1:0]       simm;
        logic [IMM22_W-1:0]    imm22;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccodes_t;

    function automatic dec_t decode_word(input logic [XLEN-1:0] w);
        dec_t d;
        d.rd      = w[29:25];
        d.rs1     = w[18:14];
        d.rs2     = w[4:0];
        d.use_imm = w[13];
        d.simm    = {{(XLEN-IMM13_W){w[IMM13_W-1]}}, w[IMM13_W-1:0]};
        d.imm22   = w[IMM22_W-1:0];
        d.kind    = OP_BAD;
        if (w == '0) begin
            d.kind = OP_HALT;
        end else begin
            case (w[31:30])
                FMT_SETHI: if (w[24:22] == OP2_SETHI) d.kind = OP_SETHI;
                FMT_ALU:   if (w[24:19] == OP3_ANDCC) d.kind = OP_ANDCC;
                FMT_MEM: begin
                    if (w[24:19] == OP3_LOAD)       d.kind = OP_LOAD;
                    else if (w[24:19] == OP3_STORE) d.kind = OP_STORE;
                end
                default: d.kind = OP_BAD;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mcc_decoder.sv
module mcc_decoder
    import mcc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    always_comb dec = decode_word(instr);
endmodule

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [1:N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
    end
endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
    import mcc_pkg::*;
(
    input  opkind_e            kind,
    input  logic [XLEN-1:0]    opa,
    input  logic [XLEN-1:0]    opb,
    input  logic [IMM22_W-1:0] imm22,
    output logic [XLEN-1:0]    result,
    output ccodes_t            cc
);
    always_comb begin
        if (kind == OP_SETHI) result = {imm22, {LOW_W{1'b0}}};
        else                  result = opa & opb;
        cc.n = result[XLEN-1];
        cc.z = (result == '0);
        cc.v = 1'b0;
        cc.c = 1'b0;
    end
endmodule

// File: rtl/mcc_core.sv
module mcc_core
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            halted,
    output logic            fault,
    output logic [CC_W-1:0] cc_flags
);
    state_e          state_q;
    logic [XLEN-1:0] pc_q, ir_q, ea_q;
    ccodes_t         cc_q;
    logic            fault_q;

    dec_t            dec;
    logic [XLEN-1:0] rd_a, rd_b, opb, alu_res, ea_calc;
    logic [RIDX_W-1:0] raddr_b;
    ccodes_t         alu_cc;
    logic            rf_we;
    logic [XLEN-1:0] rf_wdata;
    logic            is_mem;

    mcc_decoder u_dec (.instr(ir_q), .dec(dec));

    assign is_mem  = (dec.kind == OP_LOAD) || (dec.kind == OP_STORE);
    assign raddr_b = (state_q == ST_EXEC && dec.kind == OP_STORE) ? dec.rd : dec.rs2;

    mcc_regfile #(.N(NREGS), .W(XLEN)) u_rf (
        .clk(clk), .rst(rst),
        .we(rf_we), .waddr(dec.rd), .wdata(rf_wdata),
        .raddr_a(dec.rs1), .rdata_a(rd_a),
        .raddr_b(raddr_b), .rdata_b(rd_b)
    );

    assign opb     = dec.use_imm ? dec.simm : rd_b;
    assign ea_calc = rd_a + opb;

    mcc_alu u_alu (
        .kind(dec.kind), .opa(rd_a), .opb(opb), .imm22(dec.imm22),
        .result(alu_res), .cc(alu_cc)
    );

    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = alu_res;
        if (state_q == ST_EXEC && (dec.kind == OP_SETHI || dec.kind == OP_ANDCC))
            rf_we = 1'b1;
        if (state_q == ST_WBACK) begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
        end
    end

    always_comb begin
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = rd_b;
        if (state_q == ST_EXEC && is_mem) begin
            mem_addr = ea_q;
            mem_we   = (dec.kind == OP_STORE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            ea_q    <= '0;
            cc_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: state_q <= ST_LDIR;
                ST_LDIR: begin
                    ir_q    <= mem_rdata;
                    pc_q    <= pc_q + XLEN'(4);
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    ea_q <= ea_calc;
                    case (dec.kind)
                        OP_HALT: state_q <= ST_HALT;
                        OP_BAD: begin
                            fault_q <= 1'b1;
                            state_q <= ST_HALT;
                        end
                        OP_LOAD, OP_STORE: begin
                            if (ea_calc[1:0] != 2'b00) begin
                                fault_q <= 1'b1;
                                state_q <= ST_HALT;
                            end else begin
                                state_q <= ST_EXEC;
                            end
                        end
                        default: state_q <= ST_EXEC;
                    endcase
                end
                ST_EXEC: begin
                    if (dec.kind == OP_ANDCC) cc_q <= alu_cc;
                    state_q <= (dec.kind == OP_LOAD) ? ST_WBACK : ST_FETCH;
                end
                ST_WBACK: state_q <= ST_FETCH;
                default:  state_q <= ST_HALT;
            endcase
        end
    end

    assign halted   = (state_q == ST_HALT);
    assign fault    = fault_q;
    assign cc_flags = cc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LDIR) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R2

    AST_ALIGNED_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[1:0] == 2'b00)); // R8

    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R9

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_EXEC) |=> $stable(cc_flags)); // R7

    AST_CC_LOGIC: assert property (@(posedge clk) disable iff (rst)
        (cc_flags[1:0] == 2'b00)); // R7
endmodule

// File: tb/mcc_core_test.sv
`timescale 1ns/1ps
module mcc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, halted, fault;
    logic [3:0]  cc_flags;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [31:0] mem [0:63];
    logic        pk_en = 1'b0;
    logic [5:0]  pk_idx = '0;
    logic [31:0] pk_val = '0;

    always #4 clk = ~clk;

    mcc_core uut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .halted(halted), .fault(fault),
        .cc_flags(cc_flags)
    );

    always @(posedge clk) begin
        if (pk_en)       mem[pk_idx] <= pk_val;
        else if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:2]];
    end

    function automatic logic [31:0] i_mem(input logic [5:0] op3, input int rd,
                                          input int rs1, input int imm);
        return {2'b11, 5'(rd), op3, 5'(rs1), 1'b1, 13'(imm)};
    endfunction
    function automatic logic [31:0] i_ld(input int rd, input int rs1, input int imm);
        return i_mem(6'b000000, rd, rs1, imm);
    endfunction
    function automatic logic [31:0] i_st(input int rd, input int rs1, input int imm);
        return i_mem(6'b000100, rd, rs1, imm);
    endfunction
    function automatic logic [31:0] i_sethi(input int rd, input logic [21:0] k);
        return {2'b00, 5'(rd), 3'b100, k};
    endfunction
    function automatic logic [31:0] i_and_r(input int rd, input int rs1, input int rs2);
        return {2'b10, 5'(rd), 6'b010001, 5'(rs1), 1'b0, 8'b0, 5'(rs2)};
    endfunction
    function automatic logic [31:0] i_and_i(input int rd, input int rs1, input int imm);
        return {2'b10, 5'(rd), 6'b010001, 5'(rs1), 1'b1, 13'(imm)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] val);
        @(negedge clk);
        pk_en  = 1'b1;
        pk_idx = 6'(idx);
        pk_val = val;
        @(negedge clk);
        pk_en  = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) poke(i, 32'h0);
        poke(40, 32'hDEAD_BEEF);
        poke(41, 32'h0000_0090);
        poke(35, 32'h1234_5678);
        poke(42, 32'hF0F0_F0F0);
        poke(43, 32'h8F00_00FF);
        poke(48, 32'h5555_5555);
        poke(50, 32'hFFFF_FFFF);
        poke(51, 32'hFFFF_FFFF);
    endtask

    task automatic run(output int edges);
        edges = 0;
        @(negedge clk);
        rst = 1'b0;
        while (edges < 400) begin
            @(posedge clk);
            #1;
            edges++;
            if (halted) break;
        end
    endtask

    task automatic t_reset();
        int e;
        wipe();
        poke(0, 32'h0);
        @(negedge clk);
        check("R1", "halted in reset", {31'b0, halted}, 32'd0);
        check("R1", "fault in reset", {31'b0, fault}, 32'd0);
        check("R1", "cc in reset", {28'b0, cc_flags}, 32'd0);
        check("R1", "we in reset", {31'b0, mem_we}, 32'd0);
        check("R1", "first fetch address", mem_addr, 32'd0);
        run(e);
        check("R2", "zero-word halt cycles", e, 3);
        check("R9", "zero-word no fault", {31'b0, fault}, 32'd0);
    endtask

    task automatic t_sethi_store();
        int e;
        wipe();
        poke(0, i_sethi(1, 22'h2ABCDE));
        poke(1, i_st(1, 0, 32'h80));
        poke(2, 32'h0);
        run(e);
        check("R6", "set-high value stored", mem[32], {22'h2ABCDE, 10'b0});
        check("R2", "sethi+store cycles", e, 11);
        check("R7", "cc untouched by non-AND", {28'b0, cc_flags}, 32'd0);
    endtask

    task automatic t_load_store();
        int e;
        wipe();
        poke(0, i_ld(4, 0, 32'hA4));
        poke(1, i_ld(5, 4, 32'h10));
        poke(2, i_st(5, 0, 32'hC0));
        poke(3, i_ld(7, 4, -4));
        poke(4, i_st(7, 0, 32'hD0));
        poke(5, 32'h0);
        run(e);
        check("R4", "load via base+offset", mem[48], 32'hDEAD_BEEF);
        check("R4", "load negative offset", mem[52], 32'h1234_5678);
        check("R2", "load/store program cycles", e, 26);
    endtask

    task automatic t_andcc();
        int e;
        wipe();
        poke(0, i_ld(1, 0, 32'hA8));
        poke(1, i_ld(2, 0, 32'hAC));
        poke(2, i_and_r(3, 1, 2));
        poke(3, i_st(3, 0, 32'hC4));
        poke(4, 32'h0);
        run(e);
        check("R7", "AND register result", mem[49], 32'h8000_00F0);
        check("R7", "flags N set", {28'b0, cc_flags}, 32'h8);
        check("R5", "store program cycles", e, 21);
    endtask

    task automatic t_collide();
        int e;
        wipe();
        poke(0, i_ld(1, 0, 32'hA8));
        poke(1, i_and_i(1, 1, 32'h0F));
        poke(2, i_st(1, 0, 32'hC0));
        poke(3, 32'h0);
        run(e);
        check("R7", "rd==rs1 AND result", mem[48], 32'h0);
        check("R7", "flags Z set", {28'b0, cc_flags}, 32'h4);
        wipe();
        poke(0, i_ld(2, 0, 32'hAC));
        poke(1, i_and_r(0, 2, 2));
        poke(2, i_st(0, 0, 32'hC8));
        poke(3, i_ld(0, 0, 32'hA8));
        poke(4, i_st(0, 0, 32'hCC));
        poke(5, 32'h0);
        run(e);
        check("R3", "r0 after AND", mem[50], 32'h0);
        check("R3", "r0 after load", mem[51], 32'h0);
        check("R7", "flags from discarded AND", {28'b0, cc_flags}, 32'h8);
    endtask

    task automatic t_misalign();
        int e;
        wipe();
        poke(0, i_ld(1, 0, 32'hA2));
        poke(1, 32'h0);
        run(e);
        check("R8", "misaligned load fault", {31'b0, fault}, 32'd1);
        check("R8", "misaligned load halt cycles", e, 3);
        wipe();
        poke(0, i_sethi(1, 22'h1));
        poke(1, i_st(1, 0, 32'hC1));
        poke(2, 32'h0);
        run(e);
        check("R8", "misaligned store fault", {31'b0, fault}, 32'd1);
        check("R8", "no write on misaligned store", mem[48], 32'h5555_5555);
        check("R8", "misaligned store cycles", e, 7);
    endtask

    task automatic t_illegal();
        int e;
        wipe();
        poke(0, 32'h4000_0000);
        poke(1, i_st(0, 0, 32'hC0));
        run(e);
        check("R10", "illegal word fault", {31'b0, fault}, 32'd1);
        check("R10", "illegal word halt cycles", e, 3);
        check("R10", "nothing executed after", mem[48], 32'h5555_5555);
    endtask

    task automatic t_sticky();
        int e;
        int bad = 0;
        wipe();
        poke(0, 32'h0);
        poke(1, i_st(0, 0, 32'hC0));
        run(e);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!halted || mem_we) bad++;
        end
        check("R9", "halt sticky, no writes", bad, 0);
        check("R9", "memory untouched after halt", mem[48], 32'h5555_5555);
    endtask

    initial begin
        t_reset();
        t_sethi_store();
        t_load_store();
        t_andcc();
        t_collide();
        t_misalign();
        t_illegal();
        t_sticky();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule